// File: doc/BRIEF.md
# Re-Reference Interval Prediction Victim Selector

This block chooses the replacement victim for a set-associative cache. For every way of every set it holds a 2-bit prediction of how soon that block will be used again. A value of 0 means the block is expected back almost at once. A value of 3 means it is not expected for a long time. Values 1 and 2 fall in between. A hit pulls a block's prediction to 0. A newly installed block starts at 2, so a block that is never reused leaves the cache sooner than one that has shown reuse.

The cache controller presents one access at a time: a set index, a hit flag and, on a hit, the way that hit. A miss starts a victim search on that set. The search picks the lowest-numbered way predicted at 3. If no way holds 3, the search ages the whole set by one step and tries again on the next cycle. Once a victim is found, the block raises its ready output and holds the victim way. It keeps holding it until the controller pulses the fill strobe, which installs the new block at the insertion value. The block holds no tags and no data.

Top module: `rrip_replacer`

## Requirements
- R1: After synchronous active-low reset, ready is low and every way of every set holds prediction 3, so the first miss to any set selects way 0 with no aging step.
- R2: An access with the hit flag set, accepted while no search is pending, sets that way's prediction to 0 (near-immediate).
- R3: A fill strobe while ready is high writes prediction 2 into the victim way of the searched set, and ready is low from the next cycle.
- R4: The victim is the lowest-numbered way whose prediction is 3 (distant).
- R5: When no way of the searched set holds 3, every way in that set is incremented by one, saturating at 3, and the search repeats on the next cycle. Ready rises exactly N+1 clock edges after the miss is accepted, where N is the number of aging steps.
- R6: A search needs at most three aging steps, so ready rises no later than four edges after a miss is accepted.
- R7: While ready is high and no fill is given, ready stays high and the victim way does not change.
- R8: Accesses presented while a search is pending or ready is high are ignored, and so is a fill strobe given while ready is low. They change no prediction and no victim.
- R9: Updates to one set leave the predictions of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_set | input | SET_W (6) | Set index of the access |
| acc_hit | input | 1 | Access hit (1) or missed (0) |
| acc_way | input | WAY_W (2) | Way that hit, used when acc_hit is 1 |
| fill | input | 1 | Install strobe for the held victim |
| victim_way | output | WAY_W (2) | Selected victim way, valid while victim_ready is 1 |
| victim_ready | output | 1 | A distant-predicted victim has been found and is held |

## Verification
On every cycle the assertions check four things. While ready is high, the selected way really holds prediction 3 in the searched set. The victim is held steady until a fill arrives. A fill always drops ready. No search stays pending for more than four cycles. Only the bench scenarios can show the rest: the exact contents of the prediction array after hits, insertions and aging; the priority among several distant ways; the number of aging steps for each starting pattern; that other sets are left alone; and that traffic presented during a search is ignored. The bench shows these by sweeping every set and every hit pattern on a group of sets against an arithmetic reference.

// File: rtl/rrip_pkg.sv
// Package: shared constants and control-state type for the re-reference
// prediction replacer. Assumes a 2-bit prediction field.
package rrip_pkg;
    localparam int RRPV_W = 2;
    localparam logic [RRPV_W-1:0] RRPV_NEAR   = 2'd0;
    localparam logic [RRPV_W-1:0] RRPV_INSERT = 2'd2;
    localparam logic [RRPV_W-1:0] RRPV_FAR    = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_READY  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/rrip_state_store.sv
// Module: per-set prediction storage, one row of NUM_WAYS fields per set.
// Assumes at most one row write per cycle; read is combinational.
module rrip_state_store
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 64,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [SET_W-1:0]                   rd_set,
    output logic [NUM_WAYS-1:0][RRPV_W-1:0]    rd_row,
    input  logic                               wr_en,
    input  logic [SET_W-1:0]                   wr_set,
    input  logic [NUM_WAYS-1:0][RRPV_W-1:0]    wr_row
);
    logic [NUM_WAYS-1:0][RRPV_W-1:0] rows_q [NUM_SETS];

    // Storage update: reset every field to distant, else write one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    rows_q[s][w] <= RRPV_FAR;
                end
            end
        end else if (wr_en) begin
            rows_q[wr_set] <= wr_row;
        end
    end

    // Row read for the set the controller is working on.
    always_comb rd_row = rows_q[rd_set];
endmodule

// File: rtl/rrip_victim_find.sv
// Module: combinational scan of one row. Reports whether a distant way
// exists, the lowest such way, and the row aged by one saturating step.
module rrip_victim_find
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][RRPV_W-1:0] row,
    output logic                            found,
    output logic [WAY_W-1:0]                idx,
    output logic [NUM_WAYS-1:0][RRPV_W-1:0] aged_row
);
    logic [NUM_WAYS-1:0] distant;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        // Per-way distant flag and saturating age step.
        always_comb begin
            distant[g]  = (row[g] == RRPV_FAR);
            aged_row[g] = distant[g] ? RRPV_FAR : row[g] + RRPV_W'(1);
        end
    end

    // Priority pick: the lowest-numbered distant way wins.
    always_comb begin
        found = |distant;
        idx   = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (distant[w]) idx = WAY_W'(w);
        end
    end
endmodule

// File: rtl/rrip_ctrl.sv
// Module: access/search/fill sequencer. Assumes one access at a time; while a
// search is pending or a victim is held, accesses are dropped, and a fill is
// taken only while a victim is held.
module rrip_ctrl
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 64,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc_valid,
    input  logic [SET_W-1:0]                acc_set,
    input  logic                            acc_hit,
    input  logic [WAY_W-1:0]                acc_way,
    input  logic                            fill,
    input  logic [NUM_WAYS-1:0][RRPV_W-1:0] rd_row,
    input  logic                            found,
    input  logic [WAY_W-1:0]                found_idx,
    input  logic [NUM_WAYS-1:0][RRPV_W-1:0] aged_row,
    output logic [SET_W-1:0]                rd_set,
    output logic                            wr_en,
    output logic [SET_W-1:0]                wr_set,
    output logic [NUM_WAYS-1:0][RRPV_W-1:0] wr_row,
    output logic [WAY_W-1:0]                victim_way,
    output logic                            victim_ready,
    output ctrl_state_e                     state
);
    ctrl_state_e      st_q, st_d;
    logic [SET_W-1:0] cur_set_q;
    logic [WAY_W-1:0] victim_q;

    // Next-state, row selection and write-back decisions.
    always_comb begin
        st_d   = st_q;
        rd_set = (st_q == ST_IDLE) ? acc_set : cur_set_q;
        wr_en  = 1'b0;
        wr_set = rd_set;
        wr_row = rd_row;
        case (st_q)
            ST_IDLE: begin
                if (acc_valid && acc_hit) begin
                    wr_en           = 1'b1;
                    wr_row[acc_way] = RRPV_NEAR;
                end else if (acc_valid) begin
                    st_d = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (found) begin
                    st_d = ST_READY;
                end else begin
                    wr_en  = 1'b1;
                    wr_row = aged_row;
                end
            end
            ST_READY: begin
                if (fill) begin
                    wr_en            = 1'b1;
                    wr_row[victim_q] = RRPV_INSERT;
                    st_d             = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, searched set and held victim registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cur_set_q <= '0;
            victim_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && acc_valid && !acc_hit) cur_set_q <= acc_set;
            if (st_q == ST_SEARCH && found) victim_q <= found_idx;
        end
    end

    // Output view of the held victim.
    always_comb begin
        victim_way   = victim_q;
        victim_ready = (st_q == ST_READY);
        state        = st_q;
    end
endmodule

// File: rtl/rrip_replacer.sv
// Module: top of the re-reference prediction replacer. Ties storage, the
// row scanner and the sequencer together. Assumes NUM_WAYS and NUM_SETS are
// powers of two.
module rrip_replacer
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 64,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_ready
);
    logic [SET_W-1:0]                rd_set, wr_set;
    logic [NUM_WAYS-1:0][RRPV_W-1:0] rd_row, wr_row, aged_row;
    logic                            wr_en, found;
    logic [WAY_W-1:0]                found_idx;
    ctrl_state_e                     st;

    rrip_state_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_set(rd_set), .rd_row(rd_row),
        .wr_en(wr_en), .wr_set(wr_set), .wr_row(wr_row)
    );

    rrip_victim_find #(.NUM_WAYS(NUM_WAYS)) u_find (
        .row(rd_row), .found(found), .idx(found_idx), .aged_row(aged_row)
    );

    rrip_ctrl #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill(fill), .rd_row(rd_row),
        .found(found), .found_idx(found_idx), .aged_row(aged_row),
        .rd_set(rd_set), .wr_en(wr_en), .wr_set(wr_set), .wr_row(wr_row),
        .victim_way(victim_way), .victim_ready(victim_ready), .state(st)
    );
endmodule

// File: rtl/rrip_replacer_chk.sv
// Module: assertion checker bound to the replacer top. Observes ports, the
// sequencer state and the row read for the working set.
module rrip_replacer_chk
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            fill,
    input logic [WAY_W-1:0]                victim_way,
    input logic                            victim_ready,
    input ctrl_state_e                     state,
    input logic [NUM_WAYS-1:0][RRPV_W-1:0] rd_row
);
    logic [2:0] search_cnt;

    // Count consecutive search cycles for the bounded-search check.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SEARCH) search_cnt <= '0;
        else if (search_cnt != 3'd7) search_cnt <= search_cnt + 3'd1;
    end

    // R4: the held victim holds prediction 3 in the searched set.
    p_victim_distant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        victim_ready |-> rd_row[victim_way] == RRPV_FAR);

    // R7: the victim is held steady until a fill.
    p_victim_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        victim_ready && !fill |=> victim_ready && $stable(victim_way));

    // R3: a fill releases the victim.
    p_fill_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_ready && fill |=> !victim_ready);

    // R6: no more than four search cycles (three aging plus one pick).
    p_search_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEARCH |-> search_cnt < 3'd4);

    // R5: ready only ever rises out of a search.
    p_ready_from_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(victim_ready) |-> $past(state) == ST_SEARCH);
endmodule

bind rrip_replacer rrip_replacer_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fill(fill), .victim_way(victim_way),
    .victim_ready(victim_ready), .state(st), .rd_row(rd_row)
);

// File: tb/rrip_replacer_tb.sv
module rrip_replacer_tb;
    localparam int NW = 4;
    localparam int NS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [5:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;
    logic       fill = 1'b0;
    logic [1:0] victim_way;
    logic       victim_ready;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int refv [NS][NW];

    always #5 clk = ~clk;

    rrip_replacer #(.NUM_WAYS(NW), .NUM_SETS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill(fill),
        .victim_way(victim_way), .victim_ready(victim_ready)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_hit(int s, int w);
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b1; acc_set = 6'(s); acc_way = 2'(w);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_hit = 1'b0;
        refv[s][w] = 0;
    endtask

    // Miss on set s; reference computes aging steps and victim (R4, R5, R6).
    task automatic do_miss(int s, bit inject);
        int n = 0;
        int vict = -1;
        bit early = 1'b0;
        while (vict < 0) begin
            for (int w = NW - 1; w >= 0; w--) if (refv[s][w] == 3) vict = w;
            if (vict < 0) begin
                for (int w = 0; w < NW; w++) refv[s][w] = refv[s][w] + 1;
                n++;
            end
        end
        chk(n <= 3, "R6 aging steps", n, 3);
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 6'(s);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        if (inject) begin
            // R8: hit on the would-be victim and a stray fill during search.
            acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 2'(vict); fill = 1'b1;
        end
        for (int k = 0; k <= n; k++) begin
            if (victim_ready) early = 1'b1;
            @(posedge clk);
            @(negedge clk);
            acc_valid = 1'b0; acc_hit = 1'b0; fill = 1'b0;
        end
        chk(!early, "R5 ready early", int'(early), 0);
        chk(victim_ready, "R5 ready timing", int'(victim_ready), 1);
        chk(int'(victim_way) == vict, "R4 victim way", int'(victim_way), vict);
        for (int h = 0; h < 2; h++) begin
            if (inject) begin
                acc_valid = 1'b1; acc_hit = 1'b1; acc_set = 6'(s);
                acc_way = 2'(vict);
            end
            @(posedge clk);
            @(negedge clk);
            acc_valid = 1'b0; acc_hit = 1'b0;
            chk(victim_ready && int'(victim_way) == vict, "R7 victim held",
                int'(victim_way), vict);
        end
        fill = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fill = 1'b0;
        refv[s][vict] = 2;
        chk(!victim_ready, "R3 ready drops after fill", int'(victim_ready), 0);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) refv[s][w] = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!victim_ready, "R1 reset ready low", int'(victim_ready), 0);

        // R1 / R9: first miss on every set picks way 0 with no aging.
        for (int s = 0; s < NS; s++) do_miss(s, 1'b0);

        // R2 / R4 / R5: every hit pattern on sets 16..31.
        for (int m = 0; m < 16; m++) begin
            int s = 16 + m;
            for (int f = 0; f < 3; f++) do_miss(s, 1'b0);
            for (int w = 0; w < NW; w++) if (m[w]) do_hit(s, w);
            do_miss(s, m[0]);
            do_miss(s, 1'b1);
            do_miss(s, 1'b0);
        end

        // R9: an untouched set still holds the insertion pattern.
        do_miss(40, 1'b0);
        // R2: hits promote, then three aging steps on a set of near values.
        for (int w = 0; w < NW; w++) do_hit(41, w);
        do_miss(41, 1'b0);
        do_miss(41, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule